// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host read and write two banks of byte-wide registers over a four-wire SPI link in mode 0. Each access is a frame bounded by chip select. The most significant bit of the first byte picks the format. A short access is two bytes long and reaches a 6-bit bank. A long access is three bytes long and reaches a 10-bit bank. After the command bytes the block either captures a data byte from MOSI and writes it, or reads the selected register and shifts its contents out on MISO during the final byte.

SCK, chip select and MOSI are brought into the system clock through two-flop synchronisers, and all framing runs in that clock domain. A frame controller with four states tracks progress through a frame. `ST_IDLE` is the state while chip select is high. `ST_IDLE -> ST_CMD` happens when chip select goes low. `ST_CMD -> ST_LADDR` happens when a first byte with bit 7 set completes. `ST_CMD -> ST_DATA` happens when a first byte with bit 7 clear completes. `ST_LADDR -> ST_DATA` happens when the second byte of a long frame completes. `ST_DATA -> ST_CMD` happens when the data byte completes, so further frames may follow under the same chip select. Any state returns to `ST_IDLE` when chip select goes high.

The register side is a simple synchronous port that carries address, bank select, write data, one-cycle write and read strobes, and read data. It feeds an internal test register array that holds both banks.

Top module: `spi_regif`

## Requirements
- R1: Bit 7 of the first byte of a frame selects the format. 0 selects a short two-byte access to the short bank (`reg_long`=0). 1 selects a long three-byte access to the long bank (`reg_long`=1).
- R2: In a short access, bits 6:1 of the first byte are the register address, placed on `reg_addr[5:0]` with `reg_addr[9:6]`=0. Bit 0 of the first byte is the write flag (1 = write).
- R3: In a long access, the first two bytes form a 16-bit word with the first byte in the upper half. Bits 14:5 of that word are the 10-bit address and bit 4 is the write flag (1 = write).
- R4: Bits are shifted MSB first, and MOSI is sampled on rising SCK. In a write, `reg_wr` pulses for exactly one system clock after the eighth bit of the data byte, with the decoded address, bank and that byte on `reg_wdata`. It pulses only while chip select is still low.
- R5: In a read, `reg_rd` pulses for one clock once the address is complete, and never in the same cycle as `reg_wr`. During the data byte, MISO carries the register contents MSB first and changes after falling SCK edges. MISO is 0 at all other times.
- R6: If chip select rises after exactly one complete byte, the partial frame is discarded, no write happens, and `frame_err` pulses for one clock.
- R7: Chip select rising always restarts framing. Incomplete bits are dropped, and the next byte after chip select falls is decoded as a command byte. A rise after 0 whole bytes raises no error.
- R8: After a complete frame with chip select still low, the next byte is decoded as a new command byte.
- R9: A long frame ended after its two command bytes raises no error and performs no write.
- R10: The test register array holds 64 short registers and 1024 long registers. All registers are 0 after reset, and the two banks are independent.
- R11: After reset, `miso`, `reg_wr`, `reg_rd`, `frame_err`, `reg_addr` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| reg_addr | output | 10 | Decoded register address |
| reg_long | output | 1 | Bank select: 1 = long bank |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | output | 8 | Read data of the addressed register |
| frame_err | output | 1 | One-cycle pulse on a broken frame |

## Verification
On every cycle the assertions check the following: the strobes are single-cycle and mutually exclusive, a short access never carries high address bits, a write never follows a deasserted chip select, MISO is quiet while deselected, and an error pulse comes only right after chip select rises and never coincides with a write. The bench's scenarios are what show the decoding itself. Those scenarios cover bit placement of both formats, read data returned bit by bit, bank independence, back-to-back frames, and the outcomes of frames cut after 1, 2 or a few bits. The bench shows these by comparing strobes and data against its own register model.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
    localparam int BYTE_W   = 8;
    localparam int SHORT_AW = 6;
    localparam int LONG_AW  = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_LADDR,
        ST_DATA
    } frame_state_e;
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {2{RST_VAL[i]}};
            else        pipe <= {pipe[0], async_in[i]};
        end
        assign lvl[i] = pipe[1];
    end
endmodule

// File: rtl/spi_regif_regs.sv
module spi_regif_regs #(
    parameter int SHORT_N = 64,
    parameter int LONG_N  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [9:0] addr,
    input  logic       long_sel,
    input  logic [7:0] wdata,
    input  logic       wr,
    output logic [7:0] rdata
);
    localparam int SIDX = $clog2(SHORT_N);
    localparam int LIDX = $clog2(LONG_N);

    logic [7:0] short_q [SHORT_N];
    logic [7:0] long_q  [LONG_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SHORT_N; i++) short_q[i] <= '0;
            for (int i = 0; i < LONG_N; i++)  long_q[i]  <= '0;
        end else if (wr) begin
            if (long_sel) long_q[addr[LIDX-1:0]]  <= wdata;
            else          short_q[addr[SIDX-1:0]] <= wdata;
        end
    end

    assign rdata = long_sel ? long_q[addr[LIDX-1:0]] : short_q[addr[SIDX-1:0]];
endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
    import spi_regif_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_lvl,
    input  logic                cs_lvl,
    input  logic                mosi_lvl,
    input  logic [BYTE_W-1:0]   rdata,
    output logic                miso,
    output logic [LONG_AW-1:0]  addr,
    output logic                long_sel,
    output logic [BYTE_W-1:0]   wdata,
    output logic                wr,
    output logic                rd,
    output logic                frame_err
);
    localparam int BC_W = $clog2(BYTE_W);

    frame_state_e state_q, state_d;
    logic              sck_prev;
    logic [BC_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-2:0] hi_q;
    logic [BYTE_W-1:0] tx_sr;
    logic              wr_flag;

    logic              sck_rise, sck_fall, byte_done;
    logic [BYTE_W-1:0] rx_byte;

    assign sck_rise  = sck_lvl & ~sck_prev;
    assign sck_fall  = ~sck_lvl & sck_prev;
    assign byte_done = sck_rise && (bit_cnt == BC_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sr, mosi_lvl};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_lvl) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_lvl)         state_d = ST_IDLE;
                else if (byte_done) state_d = rx_byte[7] ? ST_LADDR : ST_DATA;
            end
            ST_LADDR: begin
                if (cs_lvl)         state_d = ST_IDLE;
                else if (byte_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (cs_lvl)         state_d = ST_IDLE;
                else if (byte_done) state_d = ST_CMD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev  <= 1'b0;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            hi_q      <= '0;
            tx_sr     <= '0;
            wr_flag   <= 1'b0;
            miso      <= 1'b0;
            addr      <= '0;
            long_sel  <= 1'b0;
            wdata     <= '0;
            wr        <= 1'b0;
            rd        <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            sck_prev  <= sck_lvl;
            wr        <= 1'b0;
            rd        <= 1'b0;
            frame_err <= 1'b0;
            if (cs_lvl || state_q == ST_IDLE) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
                miso    <= 1'b0;
                if (cs_lvl && (state_q == ST_LADDR || (state_q == ST_DATA && !long_sel)))
                    frame_err <= 1'b1;
            end else begin
                if (sck_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sr   <= rx_byte[BYTE_W-2:0];
                end
                if (byte_done) begin
                    unique case (state_q)
                        ST_CMD: begin
                            long_sel <= rx_byte[7];
                            if (rx_byte[7]) begin
                                hi_q <= rx_byte[BYTE_W-2:0];
                            end else begin
                                addr    <= {{(LONG_AW-SHORT_AW){1'b0}}, rx_byte[6:1]};
                                wr_flag <= rx_byte[0];
                                rd      <= ~rx_byte[0];
                            end
                        end
                        ST_LADDR: begin
                            addr    <= {hi_q, rx_byte[7:5]};
                            wr_flag <= rx_byte[4];
                            rd      <= ~rx_byte[4];
                        end
                        ST_DATA: begin
                            if (wr_flag) begin
                                wr    <= 1'b1;
                                wdata <= rx_byte;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sck_fall) begin
                    miso  <= tx_sr[BYTE_W-1];
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
                if (rd) tx_sr <= rdata;
            end
        end
    end
endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
    parameter int SHORT_N = 64,
    parameter int LONG_N  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic [9:0] reg_addr,
    output logic       reg_long,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic       frame_err
);
    logic [2:0] sync_lvl;
    logic       cs_lvl;

    spi_regif_sync #(.N(3), .RST_VAL(3'b010)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mosi, cs_n, sck}),
        .lvl      (sync_lvl)
    );

    assign cs_lvl = sync_lvl[1];

    spi_regif_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_lvl   (sync_lvl[0]),
        .cs_lvl    (cs_lvl),
        .mosi_lvl  (sync_lvl[2]),
        .rdata     (reg_rdata),
        .miso      (miso),
        .addr      (reg_addr),
        .long_sel  (reg_long),
        .wdata     (reg_wdata),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .frame_err (frame_err)
    );

    spi_regif_regs #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .long_sel (reg_long),
        .wdata    (reg_wdata),
        .wr       (reg_wr),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_lvl,
    input logic       miso,
    input logic [9:0] reg_addr,
    input logic       reg_long,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       frame_err
);
    AST_WR_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R4
    AST_WR_CS_HELD:  assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> !$past(cs_lvl)); // R4
    AST_RD_WR_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd && reg_wr)); // R5
    AST_MISO_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (cs_lvl && $past(cs_lvl)) |-> !miso); // R5
    AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ((reg_rd || reg_wr) && !reg_long) |-> (reg_addr[9:6] == 4'd0)); // R2
    AST_ERR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> ($past(cs_lvl) && !$past(cs_lvl, 2))); // R6
    AST_ERR_NO_WR:   assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> !reg_wr); // R6
    AST_ERR_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R6
endmodule

bind spi_regif spi_regif_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .miso      (miso),
    .reg_addr  (reg_addr),
    .reg_long  (reg_long),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .frame_err (frame_err)
);

// File: tb/spi_regif_tb_top.sv
module spi_regif_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, reg_long, reg_wr, reg_rd, frame_err;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #10 clk = ~clk;

    spi_regif dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .reg_addr(reg_addr), .reg_long(reg_long),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .frame_err(frame_err)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] short_m [64];
    logic [7:0] long_m  [1024];
    logic [18:0] exp_wr[$];
    logic [10:0] exp_rd[$];
    int exp_err = 0;
    logic [7:0] rx;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] got);
        got = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            sck = 1'b1;
            got[i] = miso;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    function automatic logic [7:0] scmd(input logic [5:0] a, input logic w);
        return {1'b0, a, w};
    endfunction

    function automatic logic [15:0] lcmd(input logic [9:0] a, input logic w);
        return {1'b1, a, w, 4'b0000};
    endfunction

    // frame bodies without chip select handling
    task automatic body_swrite(input logic [5:0] a, input logic [7:0] d);
        exp_wr.push_back({1'b0, 4'b0, a, d});
        xfer_bits(scmd(a, 1'b1), 8, rx);
        xfer_bits(d, 8, rx);
        short_m[a] = d;
    endtask

    task automatic body_sread(input logic [5:0] a, input string req);
        exp_rd.push_back({1'b0, 4'b0, a});
        xfer_bits(scmd(a, 1'b0), 8, rx);
        xfer_bits(8'h00, 8, rx);
        chk(rx == short_m[a], req, rx, short_m[a]);
    endtask

    task automatic body_lwrite(input logic [9:0] a, input logic [7:0] d);
        logic [15:0] w;
        w = lcmd(a, 1'b1);
        exp_wr.push_back({1'b1, a, d});
        xfer_bits(w[15:8], 8, rx);
        xfer_bits(w[7:0], 8, rx);
        xfer_bits(d, 8, rx);
        long_m[a] = d;
    endtask

    task automatic body_lread(input logic [9:0] a, input string req);
        logic [15:0] w;
        w = lcmd(a, 1'b0);
        exp_rd.push_back({1'b1, a});
        xfer_bits(w[15:8], 8, rx);
        xfer_bits(w[7:0], 8, rx);
        xfer_bits(8'h00, 8, rx);
        chk(rx == long_m[a], req, rx, long_m[a]);
    endtask

    task automatic swrite(input logic [5:0] a, input logic [7:0] d);
        cs_low(); body_swrite(a, d); cs_high();
    endtask
    task automatic sread(input logic [5:0] a, input string req);
        cs_low(); body_sread(a, req); cs_high();
    endtask
    task automatic lwrite(input logic [9:0] a, input logic [7:0] d);
        cs_low(); body_lwrite(a, d); cs_high();
    endtask
    task automatic lread(input logic [9:0] a, input string req);
        cs_low(); body_lread(a, req); cs_high();
    endtask

    // per-clock comparison against the reference queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_wr.size() == 0) chk(1'b0, "R4 unexpected write", {13'b0, reg_long, reg_addr, reg_wdata}, 0);
                else begin
                    logic [18:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_long, reg_addr, reg_wdata} == e, "R4 write strobe fields", {13'b0, reg_long, reg_addr, reg_wdata}, {13'b0, e});
                end
            end
            if (reg_rd) begin
                if (exp_rd.size() == 0) chk(1'b0, "R5 unexpected read", {21'b0, reg_long, reg_addr}, 0);
                else begin
                    logic [10:0] e;
                    e = exp_rd.pop_front();
                    chk({reg_long, reg_addr} == e, "R5 read strobe fields", {21'b0, reg_long, reg_addr}, {21'b0, e});
                end
            end
            if (frame_err) begin
                chk(exp_err > 0, "R6 frame_err pulse expected", 1, exp_err);
                if (exp_err > 0) exp_err--;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) short_m[i] = '0;
        for (int i = 0; i < 1024; i++) long_m[i] = '0;
        wait_clk(5);
        // R11 reset state
        chk({miso, reg_wr, reg_rd, frame_err} == 4'b0, "R11 reset strobes", {miso, reg_wr, reg_rd, frame_err}, 0);
        chk(reg_addr == 0 && reg_rdata == 0, "R11 reset addr/rdata", {reg_addr, reg_rdata}, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 R2 short write and read back; R10 initial zero
        sread(6'd5, "R10 short reg zero after reset");
        swrite(6'd5, 8'hA5);
        sread(6'd5, "R2 short readback");
        swrite(6'd63, 8'h5A);
        sread(6'd63, "R2 short top address");

        // R1 R3 long write/read and bank independence
        lread(10'h123, "R10 long reg zero after reset");
        lwrite(10'h123, 8'h3C);
        lread(10'h123, "R3 long readback");
        lwrite(10'h3FF, 8'hC3);
        lread(10'h3FF, "R3 long top address");
        lwrite(10'h005, 8'h77);
        sread(6'd5, "R10 short bank unaffected by long write");
        lread(10'h005, "R1 long bank distinct from short");

        // R6 one byte then chip select high
        exp_err++;
        cs_low(); xfer_bits(scmd(6'd5, 1'b1), 8, rx); cs_high();
        chk(exp_err == 0, "R6 error after one short byte", exp_err, 0);
        exp_err++;
        cs_low(); xfer_bits(8'h80, 8, rx); cs_high();
        chk(exp_err == 0, "R6 error after one long byte", exp_err, 0);
        exp_err++;
        cs_low(); xfer_bits(scmd(6'd5, 1'b1), 8, rx); xfer_bits(8'hFF, 5, rx); cs_high();
        chk(exp_err == 0, "R6 error on cut data byte", exp_err, 0);
        sread(6'd5, "R6 register unchanged after broken frame");

        // R9 long frame ended after two bytes
        begin
            logic [15:0] w;
            w = lcmd(10'h123, 1'b1);
            cs_low(); xfer_bits(w[15:8], 8, rx); xfer_bits(w[7:0], 8, rx); cs_high();
            chk(exp_err == 0, "R9 no error on two-byte long frame", exp_err, 0);
            lread(10'h123, "R9 no write on two-byte long frame");
        end

        // R7 partial bits dropped, next byte is a command
        cs_low(); xfer_bits(8'hFF, 3, rx); cs_high();
        chk(exp_err == 0, "R7 no error on partial bits", exp_err, 0);
        swrite(6'd9, 8'h96);
        sread(6'd9, "R7 frame after partial bits decodes");

        // R8 back-to-back frames in one chip select
        cs_low();
        body_swrite(6'd10, 8'h11);
        body_swrite(6'd11, 8'h22);
        body_lread(10'h3FF, "R8 third frame in same select");
        cs_high();
        sread(6'd10, "R8 first back-to-back write");
        sread(6'd11, "R8 second back-to-back write");

        // R4 R5 all-ones and alternating patterns
        swrite(6'd42, 8'hFF);
        sread(6'd42, "R4 all-ones data");
        lwrite(10'h2AA, 8'h55);
        lread(10'h2AA, "R5 alternating data MSB first");

        wait_clk(20);
        chk(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);
        chk(exp_rd.size() == 0, "R5 all expected reads seen", exp_rd.size(), 0);
        chk(exp_err == 0, "R6 all expected errors seen", exp_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule